// File: doc/BRIEF.md
# Six-Channel Sequential Sample Loader

This block is the digital input stage of a six-output display column driver. Samples of 10 bits arrive one per active clock edge on a shared bus and are steered, one after another, into six channel input registers. Which clock edge is active is picked by a static edge-select input. The walk across the channel row starts at channel 0 and counts up, or starts at channel 5 and counts down, as chosen by a direction input.

A start strobe sampled on one active edge makes the next active edge of the same polarity the first load of a new sequence. After six loads the sequence parks and ignores data until the next start. A transfer strobe sampled on a rising clock edge copies all six input registers, together with a registered invert flag, into a second bank of holding registers on the following falling edge. All six outputs therefore change at the same moment. The load clock is the input clock XOR the inverted edge-select, so edge-select must only change while the block is held in reset or is idle.

Top module: `col_sample_loader`

## Requirements
- R1: Channel c of the holding bank appears on `hold_o[c*10+9 : c*10]`, with bit 9 of each word as its most significant bit. A sequence that counts upward writes its k-th sample (k = 0 to 5) into channel k.
- R2: With `edge_sel` high, samples are loaded on rising `clk` edges. A sample loaded on a rising edge whose transfer request was sampled on that same edge is part of the copy made on the following falling edge.
- R3: With `edge_sel` low, samples are loaded on falling `clk` edges.
- R4: With `dir_sel` low, a sequence starts at channel 0 and counts upward. With `dir_sel` high, it starts at channel 5 and counts downward.
- R5: When `start` was high on the previous active edge, the current active edge begins a new sequence and writes its sample into the first channel. This also applies in the middle of a running sequence.
- R6: After reset and before the first start, data is ignored. After the sixth sample of a sequence, further data is ignored until the next start.
- R7: When `xfer` is high at a rising `clk` edge, all six input registers are copied to `hold_o` on the next falling edge. Otherwise `hold_o` and `inv_o` keep their values.
- R8: `inv_in` is sampled on the same rising edge as `xfer` and appears on `inv_o` together with the copied words.
- R9: When a copy and a load fall on the same falling edge, the holding bank receives the input-register value from before that load.
- R10: Driving `rst_n` low asynchronously clears both banks and `inv_o`, and leaves the sequencer idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | 10 | Sample data bus |
| edge_sel | input | 1 | 1: load on rising edges, 0: load on falling edges (static) |
| dir_sel | input | 1 | 0: channel 0 upward, 1: channel 5 downward |
| start | input | 1 | Sequence start strobe, qualified on the previous active edge |
| xfer | input | 1 | Transfer request, sampled on rising edges |
| inv_in | input | 1 | Output polarity request, captured with a transfer |
| hold_o | output | 60 | Six held 10-bit channel words, channel 0 in the low bits |
| inv_o | output | 1 | Held polarity flag |

## Verification
The loader runs under all four combinations of edge polarity and direction. Every sample carries a distinct value, so a wrong channel, a reversed order or an off-by-one start shows up as a misplaced word. Transfers are placed on the same cycle as the last load in both edge modes: in rising mode the new sample must be included, in falling mode it must be excluded, which separates the two edge behaviours and tests the collision rule. Data sent before any start, after the sixth load and across a restart in mid-sequence checks the ignore and restart rules, and every falling edge without a transfer confirms that the held outputs did not move.

// File: rtl/col_ldr_pkg.sv
package col_ldr_pkg;
   // Width of a counter that must hold values 0..n inclusive.
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

   // Width of an index that addresses n entries.
   function automatic int unsigned idx_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/col_ldr_seq.sv
module col_ldr_seq
   import col_ldr_pkg::*;
#(
   parameter int unsigned NCH = 6,
   localparam int unsigned CW = cnt_width(NCH),
   localparam int unsigned SW = idx_width(NCH)
) (
   input  logic          lclk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          dir_sel,
   output logic          wr_en,
   output logic [SW-1:0] wr_ch,
   output logic [CW-1:0] cnt_o
);
   logic          start_q;
   logic          act;
   logic [CW-1:0] cnt;
   logic [CW-1:0] idx;

   // A start seen on the previous active edge overrides the running count.
   always_comb begin
      idx   = start_q ? '0 : cnt;
      wr_en = start_q | (act & (cnt < CW'(NCH)));
      wr_ch = dir_sel ? (SW'(NCH - 1) - SW'(idx)) : SW'(idx);
   end

   always_ff @(posedge lclk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= 1'b0;
         act     <= 1'b0;
         cnt     <= '0;
      end else begin
         start_q <= start;
         if (wr_en) begin
            cnt <= idx + CW'(1);
            act <= 1'b1;
         end
      end
   end

   assign cnt_o = cnt;
endmodule

// File: rtl/col_ldr_in_bank.sv
module col_ldr_in_bank
   import col_ldr_pkg::*;
#(
   parameter int unsigned DW  = 10,
   parameter int unsigned NCH = 6,
   localparam int unsigned SW = idx_width(NCH)
) (
   input  logic              lclk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SW-1:0]     wr_ch,
   input  logic [DW-1:0]     din,
   output logic [NCH*DW-1:0] regs_o
);
   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic [DW-1:0] word;
      always_ff @(posedge lclk or negedge rst_n) begin
         if (!rst_n)                            word <= '0;
         else if (wr_en && (wr_ch == SW'(c)))   word <= din;
      end
      assign regs_o[c*DW +: DW] = word;
   end
endmodule

// File: rtl/col_ldr_out_bank.sv
module col_ldr_out_bank #(
   parameter int unsigned DW  = 10,
   parameter int unsigned NCH = 6,
   localparam int unsigned TW = NCH * DW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          xfer,
   input  logic          inv_in,
   input  logic [TW-1:0] in_regs,
   output logic [TW-1:0] hold_o,
   output logic          inv_o
);
   logic xfer_q;
   logic inv_q;

   // Request is latched on the rising edge and acted on at the falling edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xfer_q <= 1'b0;
         inv_q  <= 1'b0;
      end else begin
         xfer_q <= xfer;
         if (xfer) inv_q <= inv_in;
      end
   end

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_o <= '0;
         inv_o  <= 1'b0;
      end else if (xfer_q) begin
         hold_o <= in_regs;
         inv_o  <= inv_q;
      end
   end
endmodule

// File: rtl/col_sample_loader.sv
module col_sample_loader
   import col_ldr_pkg::*;
#(
   parameter int unsigned DW  = 10,
   parameter int unsigned NCH = 6,
   localparam int unsigned TW = NCH * DW,
   localparam int unsigned CW = cnt_width(NCH),
   localparam int unsigned SW = idx_width(NCH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] din,
   input  logic          edge_sel,
   input  logic          dir_sel,
   input  logic          start,
   input  logic          xfer,
   input  logic          inv_in,
   output logic [TW-1:0] hold_o,
   output logic          inv_o
);
   if (DW < 1) begin : g_bad_dw
      $error("col_sample_loader: DW must be at least 1");
   end
   if (NCH < 2) begin : g_bad_nch
      $error("col_sample_loader: NCH must be at least 2");
   end

   logic          load_clk;
   logic          wr_en;
   logic [SW-1:0] wr_ch;
   logic [CW-1:0] seq_cnt;
   logic [TW-1:0] in_flat;

   // Rising edges of load_clk follow clk when edge_sel=1, ~clk when 0.
   assign load_clk = clk ^ ~edge_sel;

   col_ldr_seq #(.NCH(NCH)) seq_i (
      .lclk    (load_clk),
      .rst_n   (rst_n),
      .start   (start),
      .dir_sel (dir_sel),
      .wr_en   (wr_en),
      .wr_ch   (wr_ch),
      .cnt_o   (seq_cnt)
   );

   col_ldr_in_bank #(.DW(DW), .NCH(NCH)) in_i (
      .lclk   (load_clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_ch  (wr_ch),
      .din    (din),
      .regs_o (in_flat)
   );

   col_ldr_out_bank #(.DW(DW), .NCH(NCH)) out_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .xfer    (xfer),
      .inv_in  (inv_in),
      .in_regs (in_flat),
      .hold_o  (hold_o),
      .inv_o   (inv_o)
   );
endmodule

// File: rtl/col_sample_loader_chk.sv
module col_sample_loader_chk #(
   parameter int unsigned DW  = 10,
   parameter int unsigned NCH = 6,
   parameter int unsigned CW  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lclk,
   input logic [DW-1:0]     din,
   input logic              dir_sel,
   input logic              start,
   input logic              xfer,
   input logic              inv_in,
   input logic [NCH*DW-1:0] in_flat,
   input logic [NCH*DW-1:0] hold_o,
   input logic              inv_o,
   input logic [CW-1:0]     cnt
);
   p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(xfer) |-> ($stable(hold_o) && $stable(inv_o)));

   p_inv_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      xfer |=> (inv_o == $past(inv_in)));

   p_reset_clear_r10: assert property (@(posedge clk)
      !rst_n |-> (hold_o == '0 && inv_o == 1'b0));

   p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(NCH));

   p_start_first_r5: assert property (@(posedge lclk) disable iff (!rst_n)
      $past(start) |=>
         (in_flat[($past(dir_sel, 2) ? NCH - 1 : 0) * DW +: DW] == $past(din)));
endmodule

bind col_sample_loader col_sample_loader_chk #(.DW(DW), .NCH(NCH), .CW(CW)) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .lclk    (load_clk),
   .din     (din),
   .dir_sel (dir_sel),
   .start   (start),
   .xfer    (xfer),
   .inv_in  (inv_in),
   .in_flat (in_flat),
   .hold_o  (hold_o),
   .inv_o   (inv_o),
   .cnt     (seq_cnt)
);

// File: tb/col_sample_loader_tb_top.sv
`timescale 1ns/1ps
module col_sample_loader_tb_top;
   localparam int DW  = 10;
   localparam int NCH = 6;
   localparam int TW  = DW * NCH;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [DW-1:0] din = '0;
   logic          edge_sel = 1'b1;
   logic          dir_sel = 1'b0;
   logic          start = 1'b0;
   logic          xfer = 1'b0;
   logic          inv_in = 1'b0;
   logic [TW-1:0] hold_o;
   logic          inv_o;

   always #2.5 clk = ~clk;

   col_sample_loader dut_i (.*);

   int n_chk = 0;
   int n_fail = 0;
   string cur_req = "R10";

   // Reference model
   logic [DW-1:0] m_in [NCH];
   logic          m_startq, m_act;
   int            m_cnt;
   logic [TW:0]   q[$];
   logic [TW:0]   last_exp = '0;
   logic          xfer_seen = 1'b0;

   task automatic check(input logic ok, input string req,
                        input logic [TW:0] act, input logic [TW:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [TW:0] snap(input logic iv);
      logic [TW:0] r;
      r[TW] = iv;
      for (int c = 0; c < NCH; c++) r[c*DW +: DW] = m_in[c];
      return r;
   endfunction

   task automatic mdl_load(input logic [DW-1:0] d, input logic s);
      if (m_startq) begin
         m_cnt = 0;
         m_act = 1'b1;
      end
      if (m_act && m_cnt < NCH) begin
         m_in[dir_sel ? NCH - 1 - m_cnt : m_cnt] = d;
         m_cnt++;
      end
      m_startq = s;
   endtask

   // One clock cycle of stimulus: driven after a falling edge.
   task automatic cyc(input logic [DW-1:0] d, input logic s, input logic x, input logic iv);
      @(negedge clk); #1;
      din = d; start = s; xfer = x; inv_in = iv;
      if (edge_sel) begin
         mdl_load(d, s);
         if (x) q.push_back(snap(iv));
      end else begin
         if (x) q.push_back(snap(iv));
         mdl_load(d, s);
      end
   endtask

   task automatic do_reset(input logic es, input logic ds);
      @(negedge clk); #1;
      rst_n = 1'b0; din = '0; start = 1'b0; xfer = 1'b0; inv_in = 1'b0;
      #1;
      edge_sel = es; dir_sel = ds;
      for (int c = 0; c < NCH; c++) m_in[c] = '0;
      m_startq = 1'b0; m_act = 1'b0; m_cnt = 0;
      q.delete();
      last_exp = '0;
      #6;
      check(hold_o == '0 && inv_o == 1'b0, "R10", {inv_o, hold_o}, '0);
      @(negedge clk); #1;
      rst_n = 1'b1;
   endtask

   // Full sequence: start, six samples; transfer on cycle xk (-1 none).
   task automatic run_seq(input int base, input int xk);
      cyc(10'h3FF, 1'b1, 1'b0, 1'b0);
      for (int k = 0; k < NCH; k++)
         cyc(DW'(base + k * 37), 1'b0, (k == xk), 1'b0);
   endtask

   // Monitor: compares held outputs after each falling edge.
   always @(posedge clk) xfer_seen = xfer;

   always @(negedge clk) begin
      #0.5;
      if (rst_n) begin
         if (xfer_seen) begin
            if (q.size() == 0) begin
               check(1'b0, cur_req, {inv_o, hold_o}, last_exp);
            end else begin
               last_exp = q.pop_front();
               check({inv_o, hold_o} === last_exp, cur_req, {inv_o, hold_o}, last_exp);
            end
         end else begin
            check({inv_o, hold_o} === last_exp, "R7 hold", {inv_o, hold_o}, last_exp);
         end
      end
   end

   initial begin
      #(200000 * 5);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      // Rising edge, upward
      cur_req = "R10";
      do_reset(1'b1, 1'b0);
      cur_req = "R6 idle";
      for (int k = 0; k < 3; k++) cyc(DW'(100 + k), 1'b0, 1'b0, 1'b0);
      cyc(10'h155, 1'b0, 1'b1, 1'b0);
      cur_req = "R1 R2 R4 R5";
      run_seq(16, 5);
      cur_req = "R6 done";
      for (int k = 0; k < 3; k++) cyc(DW'(700 + k), 1'b0, 1'b0, 1'b0);
      cyc(10'h2AA, 1'b0, 1'b1, 1'b0);
      cur_req = "R8";
      cyc(10'h001, 1'b0, 1'b1, 1'b1);
      cyc(10'h002, 1'b0, 1'b1, 1'b0);
      cyc(10'h003, 1'b0, 0, 0);
      cyc(10'h004, 1'b0, 1'b1, 1'b1);
      cur_req = "R5 restart";
      cyc(10'h3FF, 1'b1, 1'b0, 1'b0);
      cyc(10'h011, 1'b0, 1'b0, 1'b0);
      cyc(10'h022, 1'b1, 1'b0, 1'b0);
      cyc(10'h033, 1'b0, 1'b0, 1'b0);
      cyc(10'h044, 1'b0, 1'b1, 1'b0);
      cyc(10'h055, 1'b0, 1'b1, 1'b0);

      // Rising edge, downward
      do_reset(1'b1, 1'b1);
      cur_req = "R2 R4 down";
      run_seq(300, 3);
      cyc(10'h000, 1'b0, 1'b1, 1'b0);

      // Falling edge, downward, collision on the last load
      do_reset(1'b0, 1'b1);
      cur_req = "R3 R4 R9";
      run_seq(500, 2);
      cyc(10'h000, 1'b0, 1'b0, 1'b0);
      run_seq(40, 5);
      cyc(10'h000, 1'b0, 1'b1, 1'b1);
      cur_req = "R7";
      for (int k = 0; k < 4; k++) cyc(DW'(k), 1'b0, 1'b0, 1'b1);

      // Falling edge, upward
      do_reset(1'b0, 1'b0);
      cur_req = "R1 R3";
      run_seq(800, -1);
      cyc(10'h0F0, 1'b0, 1'b1, 1'b1);
      cur_req = "R6 done";
      cyc(10'h0AB, 1'b0, 1'b0, 1'b0);
      cyc(10'h0CD, 1'b0, 1'b1, 1'b0);

      // Reset after holding non-zero data
      cur_req = "R10";
      do_reset(1'b1, 1'b0);
      cyc(10'h000, 1'b0, 1'b1, 1'b0);
      cyc(10'h000, 1'b0, 1'b0, 1'b0);
      cyc(10'h000, 1'b0, 1'b0, 1'b0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule